// File: doc/BRIEF.md
# Flash operation status generator

This block produces the status a parallel NOR flash reports while one of its internal program or erase algorithms runs. An upstream command decoder hands it a one-cycle strobe to start a program or an erase. With the strobe come the target sector, the per-sector lock flags, a chip-wide versus single-sector erase select, the data to be programmed and the data already stored at the target. From these the block decides how long the device stays busy and whether the array may be changed at the end.

While an operation runs, the ready/busy output is low and every read returns a status word instead of array data. That word holds a bit that flips on each read, a sticky timeout flag and a flag that shows a single-sector erase is under way. When the operation ends, reads return the array word again. A one-cycle commit strobe tells the array model to apply the change, and it is raised only for an operation that really succeeded. A locked target gives a busy period of fixed length with no commit. A program that tries to turn a 0 bit back into 1 stalls until the pulse limit runs out, then reports a timeout and stays there until a reset command arrives. All durations are parameters in clock cycles.

Top module: `flash_op_status`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `rdy_busy_n` is 1, `done_stb` is 0 and `rd_word` equals `array_word`.
- R2: A start strobe sampled while ready makes `rdy_busy_n` 0 from the next cycle. For an unlocked, valid program it stays 0 for exactly PROG_CYC cycles. In the cycle where `rdy_busy_n` returns to 1, `done_stb` is 1 for that single cycle.
- R3: While busy, `rd_word` is zero except bit 6 (flip bit), bit 5 (timeout) and bit 3 (sector erase). Bit 6 reads 0 on the first cycle of an operation and inverts after every cycle in which `rd_stb` is high. It holds its value in cycles without `rd_stb`.
- R4: Whenever `rdy_busy_n` is 1, `rd_word` equals `array_word`.
- R5: A program whose target sector has its bit set in `sect_lock` stays busy for PROT_PROG_CYC cycles and gives no `done_stb`.
- R6: An erase of an unlocked target stays busy for ERASE_CYC cycles and then raises `done_stb`. Bit 3 is 1 for the whole busy time of a single-sector erase (`erase_all`=0) and 0 for a chip erase (`erase_all`=1). A chip erase with only some sectors locked counts as unlocked.
- R7: A chip erase with every `sect_lock` bit set, or a single-sector erase of a locked sector, stays busy for PROT_ERASE_CYC cycles and gives no `done_stb`.
- R8: A program to an unlocked sector where `prog_data & ~cell_data` is nonzero stays busy with bit 5 at 0 for PULSE_LIMIT cycles. It then stays busy with bit 5 at 1 and bit 6 still flipping on reads, and it never raises `done_stb`.
- R9: In the timeout state, `reset_cmd` returns the block to ready on the next cycle, with no `done_stb`. During any other busy operation, `reset_cmd` has no effect on its length or outcome.
- R10: Start strobes that arrive while busy are ignored. They neither extend nor restart the running operation.
- R11: If `start_prog` and `start_erase` are high together, the program is carried out and the erase is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_prog | input | 1 | One-cycle strobe: start a program |
| start_erase | input | 1 | One-cycle strobe: start an erase |
| erase_all | input | 1 | 1 = chip erase, 0 = single-sector erase |
| tgt_sector | input | SECT_W | Target sector of the program or single-sector erase |
| sect_lock | input | 2**SECT_W | Per-sector lock flags |
| prog_data | input | 8 | Data to be programmed |
| cell_data | input | 8 | Data currently stored at the program address |
| reset_cmd | input | 1 | Reset command from the decoder |
| rd_stb | input | 1 | Read cycle strobe |
| array_word | input | 8 | Array data at the read address |
| rdy_busy_n | output | 1 | 1 = ready, 0 = operation in progress |
| rd_word | output | 8 | Read data: status word while busy, array data when ready |
| done_stb | output | 1 | One-cycle commit strobe for a successful operation |

## Verification
The assertions assume that a busy period is always followed by ready before a new operation can begin. This holds because start strobes are ignored while busy, so the flip bit can be compared across any two neighbouring busy cycles. They also assume that `reset_cmd` is the only way out of the timeout state. The stimulus raises start strobes and `reset_cmd` in the middle of busy periods on purpose, to test that they are ignored. Reads are interleaved in an irregular pattern, so both the flip and the hold of bit 6 are covered in every operation.

// File: rtl/flash_stat_pkg.sv
package flash_stat_pkg;

    localparam int DW      = 8;
    localparam int TGL_BIT = 6;
    localparam int TO_BIT  = 5;
    localparam int ES_BIT  = 3;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_STALL,
        ST_FAIL
    } run_state_e;

    typedef enum logic [1:0] {
        JOB_PROG,
        JOB_ERASE_SECT,
        JOB_ERASE_CHIP
    } job_e;

    typedef struct packed {
        job_e job;
        logic shielded;   // target locked: fake busy, no change
        logic overdrive;  // tries to raise a cleared bit
    } job_plan_t;

    function automatic int max_i(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic logic raises_cleared(input logic [DW-1:0] pd,
                                            input logic [DW-1:0] cd);
        return |(pd & ~cd);
    endfunction

    function automatic logic [DW-1:0] pack_status(input logic tgl,
                                                  input logic to,
                                                  input logic es);
        logic [DW-1:0] w;
        w         = '0;
        w[TGL_BIT] = tgl;
        w[TO_BIT]  = to;
        w[ES_BIT]  = es;
        return w;
    endfunction

endpackage

// File: rtl/fos_classify.sv
module fos_classify
    import flash_stat_pkg::*;
#(
    parameter int SECT_W         = 3,
    parameter int PROG_CYC       = 20,
    parameter int ERASE_CYC      = 60,
    parameter int PROT_PROG_CYC  = 250,
    parameter int PROT_ERASE_CYC = 12500,
    parameter int PULSE_LIMIT    = 1000,
    parameter int CNT_W          = 14
) (
    input  logic                     start_prog,
    input  logic                     start_erase,
    input  logic                     erase_all,
    input  logic [SECT_W-1:0]        tgt_sector,
    input  logic [(1<<SECT_W)-1:0]   sect_lock,
    input  logic [DW-1:0]            prog_data,
    input  logic [DW-1:0]            cell_data,
    output logic                     go,
    output job_plan_t                plan,
    output logic [CNT_W-1:0]         len_m1
);

    logic lock_hit;

    assign go       = start_prog | start_erase;
    assign lock_hit = sect_lock[tgt_sector];

    always_comb begin
        plan = '0;
        if (start_prog) begin
            plan.job       = JOB_PROG;
            plan.shielded  = lock_hit;
            plan.overdrive = !lock_hit && raises_cleared(prog_data, cell_data);
        end else if (erase_all) begin
            plan.job      = JOB_ERASE_CHIP;
            plan.shielded = &sect_lock;
        end else begin
            plan.job      = JOB_ERASE_SECT;
            plan.shielded = lock_hit;
        end
    end

    always_comb begin
        if (plan.job == JOB_PROG) begin
            if (plan.shielded)       len_m1 = CNT_W'(PROT_PROG_CYC - 1);
            else if (plan.overdrive) len_m1 = CNT_W'(PULSE_LIMIT - 1);
            else                     len_m1 = CNT_W'(PROG_CYC - 1);
        end else begin
            if (plan.shielded)       len_m1 = CNT_W'(PROT_ERASE_CYC - 1);
            else                     len_m1 = CNT_W'(ERASE_CYC - 1);
        end
    end

endmodule

// File: rtl/fos_timer.sv
module fos_timer #(
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             run,
    output logic             expired
);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (run && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == '0);

endmodule

// File: rtl/fos_seq.sv
module fos_seq
    import flash_stat_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       go,
    input  job_plan_t  plan,
    input  logic       expired,
    input  logic       rd_stb,
    input  logic       reset_cmd,
    output run_state_e state,
    output logic       load,
    output logic       tgl,
    output logic       to_flag,
    output logic       es_flag,
    output logic       done_stb
);

    logic fake_q;

    assign load = (state == ST_IDLE) && go;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            fake_q   <= 1'b0;
            tgl      <= 1'b0;
            to_flag  <= 1'b0;
            es_flag  <= 1'b0;
            done_stb <= 1'b0;
        end else begin
            done_stb <= 1'b0;
            if (state != ST_IDLE && rd_stb) begin
                tgl <= ~tgl;
            end
            unique case (state)
                ST_IDLE: begin
                    if (go) begin
                        fake_q  <= plan.shielded;
                        tgl     <= 1'b0;
                        to_flag <= 1'b0;
                        es_flag <= (plan.job == JOB_ERASE_SECT);
                        state   <= plan.overdrive ? ST_STALL : ST_RUN;
                    end
                end
                ST_RUN: begin
                    if (expired) begin
                        state    <= ST_IDLE;
                        es_flag  <= 1'b0;
                        done_stb <= !fake_q;
                    end
                end
                ST_STALL: begin
                    if (expired) begin
                        state   <= ST_FAIL;
                        to_flag <= 1'b1;
                    end
                end
                ST_FAIL: begin
                    if (reset_cmd) begin
                        state   <= ST_IDLE;
                        to_flag <= 1'b0;
                        es_flag <= 1'b0;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/flash_op_status.sv
module flash_op_status
    import flash_stat_pkg::*;
#(
    parameter int SECT_W         = 3,
    parameter int PROG_CYC       = 20,
    parameter int ERASE_CYC      = 60,
    parameter int PROT_PROG_CYC  = 250,
    parameter int PROT_ERASE_CYC = 12500,
    parameter int PULSE_LIMIT    = 1000
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   start_prog,
    input  logic                   start_erase,
    input  logic                   erase_all,
    input  logic [SECT_W-1:0]      tgt_sector,
    input  logic [(1<<SECT_W)-1:0] sect_lock,
    input  logic [7:0]             prog_data,
    input  logic [7:0]             cell_data,
    input  logic                   reset_cmd,
    input  logic                   rd_stb,
    input  logic [7:0]             array_word,
    output logic                   rdy_busy_n,
    output logic [7:0]             rd_word,
    output logic                   done_stb
);

    localparam int LONGEST = max_i(max_i(PROG_CYC, ERASE_CYC),
                                   max_i(max_i(PROT_PROG_CYC, PROT_ERASE_CYC),
                                         PULSE_LIMIT));
    localparam int CNT_W = $clog2(LONGEST + 1);

    logic             go;
    job_plan_t        plan;
    logic [CNT_W-1:0] len_m1;
    logic             expired;
    run_state_e       state;
    logic             load;
    logic             tgl;
    logic             to_flag;
    logic             es_flag;
    logic             timing;

    fos_classify #(
        .SECT_W         (SECT_W),
        .PROG_CYC       (PROG_CYC),
        .ERASE_CYC      (ERASE_CYC),
        .PROT_PROG_CYC  (PROT_PROG_CYC),
        .PROT_ERASE_CYC (PROT_ERASE_CYC),
        .PULSE_LIMIT    (PULSE_LIMIT),
        .CNT_W          (CNT_W)
    ) u_classify (
        .start_prog  (start_prog),
        .start_erase (start_erase),
        .erase_all   (erase_all),
        .tgt_sector  (tgt_sector),
        .sect_lock   (sect_lock),
        .prog_data   (prog_data),
        .cell_data   (cell_data),
        .go          (go),
        .plan        (plan),
        .len_m1      (len_m1)
    );

    assign timing = (state == ST_RUN) || (state == ST_STALL);

    fos_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .load_val (len_m1),
        .run      (timing),
        .expired  (expired)
    );

    fos_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .go        (go),
        .plan      (plan),
        .expired   (expired),
        .rd_stb    (rd_stb),
        .reset_cmd (reset_cmd),
        .state     (state),
        .load      (load),
        .tgl       (tgl),
        .to_flag   (to_flag),
        .es_flag   (es_flag),
        .done_stb  (done_stb)
    );

    assign rdy_busy_n = (state == ST_IDLE);
    assign rd_word    = rdy_busy_n ? array_word : pack_status(tgl, to_flag, es_flag);

endmodule

// File: rtl/flash_op_status_chk.sv
module flash_op_status_chk (
    input logic       clk,
    input logic       rst,
    input logic       rdy_busy_n,
    input logic       rd_stb,
    input logic       reset_cmd,
    input logic       start_prog,
    input logic       start_erase,
    input logic [7:0] rd_word,
    input logic [7:0] array_word,
    input logic       done_stb
);

    p_idle_data_r4: assert property (@(posedge clk) disable iff (rst)
        rdy_busy_n |-> (rd_word == array_word));

    p_start_busy_r2: assert property (@(posedge clk) disable iff (rst)
        (rdy_busy_n && (start_prog || start_erase)) |=> !rdy_busy_n);

    p_done_edge_r2: assert property (@(posedge clk) disable iff (rst)
        done_stb |-> (rdy_busy_n && $past(!rdy_busy_n)));

    p_toggle_flip_r3: assert property (@(posedge clk) disable iff (rst)
        (!rdy_busy_n && rd_stb) |=> (rdy_busy_n || (rd_word[6] != $past(rd_word[6]))));

    p_toggle_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!rdy_busy_n && !rd_stb) |=> (rdy_busy_n || $stable(rd_word[6])));

    p_busy_pad_r3: assert property (@(posedge clk) disable iff (rst)
        !rdy_busy_n |-> ((rd_word & 8'h97) == 8'h00));

    p_fail_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        (!rdy_busy_n && rd_word[5] && !reset_cmd) |=> (!rdy_busy_n && rd_word[5]));

    p_erase_flag_steady_r6: assert property (@(posedge clk) disable iff (rst)
        (!rdy_busy_n && $past(!rdy_busy_n)) |-> $stable(rd_word[3]));

endmodule

bind flash_op_status flash_op_status_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .rdy_busy_n  (rdy_busy_n),
    .rd_stb      (rd_stb),
    .reset_cmd   (reset_cmd),
    .start_prog  (start_prog),
    .start_erase (start_erase),
    .rd_word     (rd_word),
    .array_word  (array_word),
    .done_stb    (done_stb)
);

// File: tb/sim_flash_op_status.sv
`timescale 1ns/1ps
module sim_flash_op_status;

    localparam int SW    = 3;
    localparam int T_PRG = 5;
    localparam int T_ERS = 9;
    localparam int T_PPR = 3;
    localparam int T_PER = 7;
    localparam int T_LIM = 12;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start_prog = 1'b0;
    logic          start_erase = 1'b0;
    logic          erase_all = 1'b0;
    logic [SW-1:0] tgt_sector = '0;
    logic [7:0]    sect_lock = '0;
    logic [7:0]    prog_data = '0;
    logic [7:0]    cell_data = '0;
    logic          reset_cmd = 1'b0;
    logic          rd_stb = 1'b0;
    logic [7:0]    array_word = 8'h5A;
    logic          rdy_busy_n;
    logic [7:0]    rd_word;
    logic          done_stb;

    int total = 0;
    int bad   = 0;
    bit ended = 0;

    always #4 clk = ~clk;

    flash_op_status #(
        .SECT_W(SW), .PROG_CYC(T_PRG), .ERASE_CYC(T_ERS),
        .PROT_PROG_CYC(T_PPR), .PROT_ERASE_CYC(T_PER), .PULSE_LIMIT(T_LIM)
    ) u0 (
        .clk(clk), .rst(rst), .start_prog(start_prog), .start_erase(start_erase),
        .erase_all(erase_all), .tgt_sector(tgt_sector), .sect_lock(sect_lock),
        .prog_data(prog_data), .cell_data(cell_data), .reset_cmd(reset_cmd),
        .rd_stb(rd_stb), .array_word(array_word), .rdy_busy_n(rdy_busy_n),
        .rd_word(rd_word), .done_stb(done_stb)
    );

    typedef struct {
        string      req;
        bit         e_rdy;
        logic [7:0] e_word;
        bit         e_done;
    } item_t;

    item_t sb[$];

    function automatic logic [7:0] stat(input bit t, input bit o, input bit e);
        return {1'b0, t, o, 1'b0, e, 3'b000};
    endfunction

    task automatic push(input string req, input bit r, input logic [7:0] w, input bit d);
        item_t it;
        it.req = req; it.e_rdy = r; it.e_word = w; it.e_done = d;
        sb.push_back(it);
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // monitor: compare the item for the current cycle away from the edge
    always @(negedge clk) begin
        if (sb.size() != 0) begin
            item_t it;
            it = sb.pop_front();
            total++;
            if (rdy_busy_n !== it.e_rdy) begin
                bad++;
                $display("FAIL %s rdy_busy_n got=%0b exp=%0b t=%0t", it.req, rdy_busy_n, it.e_rdy, $time);
            end
            total++;
            if (rd_word !== it.e_word) begin
                bad++;
                $display("FAIL %s rd_word got=%02h exp=%02h t=%0t", it.req, rd_word, it.e_word, $time);
            end
            total++;
            if (done_stb !== it.e_done) begin
                bad++;
                $display("FAIL %s done_stb got=%0b exp=%0b t=%0t", it.req, done_stb, it.e_done, $time);
            end
        end
    end

    // driver: one operation, expected timeline computed from the requirements
    task automatic run_op(input string req, input bit sp, input bit se, input bit chip,
                          input logic [SW-1:0] sect, input logic [7:0] lock,
                          input logic [7:0] pd, input logic [7:0] cd,
                          input int dur, input bit es, input bit commit,
                          input bit stall, input bit poke);
        bit tg;
        tg = 1'b0;
        start_prog = sp; start_erase = se; erase_all = chip; tgt_sector = sect;
        sect_lock = lock; prog_data = pd; cell_data = cd; rd_stb = 1'b0;
        push(req, 1'b1, array_word, 1'b0);
        tick();
        start_prog = 1'b0; start_erase = 1'b0;
        for (int i = 0; i < dur; i++) begin
            rd_stb = ((i % 3) != 1);
            reset_cmd = poke && (i == 1);          // R9: ignored while running
            if (poke && i == 2) begin              // R10: restart ignored
                start_prog = 1'b1; start_erase = 1'b1;
            end
            push(req, 1'b0, stat(tg, 1'b0, es), 1'b0);
            if (rd_stb) tg = ~tg;
            tick();
            reset_cmd = 1'b0; start_prog = 1'b0; start_erase = 1'b0;
        end
        if (stall) begin
            for (int i = 0; i < 4; i++) begin
                rd_stb = (i != 2);
                push("R8", 1'b0, stat(tg, 1'b1, 1'b0), 1'b0);
                if (rd_stb) tg = ~tg;
                tick();
            end
            rd_stb = 1'b0;
            reset_cmd = 1'b1;
            push("R9", 1'b0, stat(tg, 1'b1, 1'b0), 1'b0);
            tick();
            reset_cmd = 1'b0;
        end
        rd_stb = 1'b1;
        push(stall ? "R9" : req, 1'b1, array_word, commit);
        tick();
        rd_stb = 1'b0;
        push("R4", 1'b1, array_word, 1'b0);
        tick();
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!ended) begin
            bad++; total++;
            $display("FAIL watchdog expired total=%0d", total);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        tick();
        tick();
        push("R1", 1'b1, array_word, 1'b0);
        tick();
        rst = 1'b0;
        push("R1", 1'b1, array_word, 1'b0);
        tick();

        array_word = 8'hC3;
        run_op("R2", 1, 0, 0, 3'd1, 8'h00, 8'h0F, 8'hFF, T_PRG, 0, 1, 0, 1);
        array_word = 8'h11;
        run_op("R5", 1, 0, 0, 3'd2, 8'h04, 8'h0F, 8'hFF, T_PPR, 0, 0, 0, 0);
        array_word = 8'hFF;
        run_op("R6", 0, 1, 0, 3'd5, 8'h04, 8'h00, 8'h00, T_ERS, 1, 1, 0, 0);
        array_word = 8'h7E;
        run_op("R6", 0, 1, 1, 3'd0, 8'hF7, 8'h00, 8'h00, T_ERS, 0, 1, 0, 0);
        array_word = 8'h42;
        run_op("R7", 0, 1, 1, 3'd0, 8'hFF, 8'h00, 8'h00, T_PER, 0, 0, 0, 0);
        array_word = 8'h24;
        run_op("R7", 0, 1, 0, 3'd6, 8'h40, 8'h00, 8'h00, T_PER, 1, 0, 0, 0);
        array_word = 8'h01;
        run_op("R8", 1, 0, 0, 3'd3, 8'h00, 8'h81, 8'h01, T_LIM, 0, 0, 1, 0);
        array_word = 8'h99;
        run_op("R11", 1, 1, 0, 3'd4, 8'h00, 8'h10, 8'hF0, T_PRG, 0, 1, 0, 0);
        array_word = 8'h66;
        run_op("R10", 1, 0, 0, 3'd7, 8'h00, 8'h00, 8'h00, T_PRG, 0, 1, 0, 1);

        tick();
        ended = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule